// File: doc/BRIEF.md
# Single-Wire Bus Device Bit Responder

This block is the device-side bit layer for an open-drain single-wire bus with a pull-up. It watches the shared line through a synchroniser and measures low periods. A low period long enough to be a bus reset is reported upward, and the block answers it with a delayed presence pulse. Every other falling edge that survives a short deglitch interval opens a time slot. In that slot the block either samples the master's write bit or drives a bit that the layer above supplies. The block never drives the line high. Its only output to the line is a pull-down enable, which goes to an external open-drain pad.

Received bits move upward as a one-cycle `rx_valid` strobe with `rx_bit`. There is no back-pressure on this path, because the master owns the bus timing; the consumer must take each strobe in the cycle it appears. Transmit bits use a valid/ready pair. The layer above holds `tx_valid` and `tx_bit` stable for as long as it wants its next slot to be a read slot. `tx_ready` pulses for one cycle when a slot is confirmed, whether or not `tx_valid` is high. A slot in which `tx_valid` is high during that pulse is a read slot and consumes the bit. A slot in which `tx_valid` is low is a write slot. `tx_ready` never depends on `tx_valid`. All timing is given in microseconds and scaled by the clock-cycles-per-microsecond parameter.

Top module: `owire_bit_responder`

## Requirements
- R1: When the synchronised line has been low for `RESET_US` µs (480 µs by default), `reset_seen` pulses for exactly one cycle. This holds from any state, including the middle of a slot. A low of 470 µs produces no `reset_seen`.
- R2: After a detected reset, once the line goes high again, the block waits `PRES_DLY_US` µs (30 µs), then asserts `pull_low` for exactly `PRES_WID_US` µs (120 µs).
- R3: In a write slot (`tx_valid` low at confirmation), if the line is high `SAMPLE_US` µs (30 µs) after the falling edge, one `rx_valid` strobe is issued with `rx_bit` = 1.
- R4: In a write slot, if the line is still low at the sample point and rises before `SLOT_MAX_US` µs (120 µs) from the edge, one `rx_valid` strobe with `rx_bit` = 0 is issued on the rise.
- R5: A low that is still present `SLOT_MAX_US` µs after the edge but ends before the reset length produces no `rx_valid` strobe and no `reset_seen`.
- R6: A low shorter than `GLITCH_US` µs (1 µs) produces no `rx_valid` and no accepted `tx_ready` handshake, and no `pull_low`.
- R7: A slot confirmed while `tx_valid` is high is a read slot. `tx_ready` pulses once and no `rx_valid` is issued. With `tx_bit` = 0, `pull_low` is asserted for `(HOLD_US - GLITCH_US)` µs, from confirmation until 30 µs after the edge, whatever the master does. With `tx_bit` = 1, `pull_low` stays deasserted.
- R8: After a slot, one clock cycle of high line re-arms the block, so two write slots separated by 1 µs of recovery both yield a bit.
- R9: `rx_valid`, `reset_seen` and `tx_ready` are single-cycle strobes. `pull_low` is asserted only during a presence pulse or a read-0 hold, and never for longer than the presence width.
- R10: While `rst_n` is low, `pull_low`, `rx_valid`, `reset_seen` and `tx_ready` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; `CLKS_PER_US` cycles per microsecond |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_in | input | 1 | Raw line level, asynchronous to `clk` |
| pull_low | output | 1 | Enable for the open-drain pull-down of the line |
| rx_valid | output | 1 | One-cycle strobe: a write-slot bit was received |
| rx_bit | output | 1 | Received bit, valid with `rx_valid` |
| reset_seen | output | 1 | One-cycle strobe: a bus reset low was measured |
| tx_valid | input | 1 | A bit is offered for the next read slot |
| tx_bit | input | 1 | Bit to send in the next read slot |
| tx_ready | output | 1 | One-cycle slot confirmation; handshake when `tx_valid` is high |

## Verification
The bound checker watches, on every cycle, that the three strobes never last two cycles and that a received bit is only reported after the line was seen high. It also checks that a slot is confirmed only while the line is low, that no bit is received in a confirmation cycle, that the pull-down is released once a reset is reported, and that no pull-down run outlasts the presence width. The exact presence delay and width, the read-0 hold length, deglitch rejection, the drop of over-long slots, the 470/500 µs reset boundary and re-arming after 1 µs of recovery depend on stimulus sequences, so only the bench's scenarios demonstrate them.

// File: rtl/owire_resp_pkg.sv
package owire_resp_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CONFIRM,
    ST_READ,
    ST_WSAMP,
    ST_WZERO,
    ST_WAIT_HI,
    ST_RST_HI,
    ST_PDELAY,
    ST_PLOW
  } ow_state_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/owire_line_sync.sv
module owire_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_raw,
  output logic line_s,
  output logic line_fall
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  // the line idles high, so reset fills the chain with ones
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '1;
      prev_q <= 1'b1;
    end else begin
      sh_q   <= {sh_q[STAGES-2:0], line_raw};
      prev_q <= sh_q[STAGES-1];
    end
  end

  assign line_s    = sh_q[STAGES-1];
  assign line_fall = prev_q & ~line_s;
endmodule

// File: rtl/owire_low_meter.sv
module owire_low_meter #(
  parameter int unsigned LIMIT = 24000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_s,
  output logic long_low
);
  localparam int unsigned CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  // saturates at LIMIT so one long low reports only once
  always_ff @(posedge clk) begin
    if (!rst_n)                  cnt_q <= '0;
    else if (line_s)             cnt_q <= '0;
    else if (cnt_q != CW'(LIMIT)) cnt_q <= cnt_q + 1'b1;
  end

  assign long_low = ~line_s && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/owire_slot_timer.sv
module owire_slot_timer #(
  parameter int unsigned TMAX = 6000
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  output logic [$clog2(TMAX+1)-1:0] t
);
  localparam int unsigned TW = $clog2(TMAX + 1);

  always_ff @(posedge clk) begin
    if (!rst_n)              t <= '0;
    else if (clr)            t <= '0;
    else if (t != TW'(TMAX)) t <= t + 1'b1;
  end
endmodule

// File: rtl/owire_bit_responder.sv
module owire_bit_responder
  import owire_resp_pkg::*;
#(
  parameter int unsigned CLKS_PER_US  = 50,
  parameter int unsigned SYNC_STAGES  = 2,
  parameter int unsigned GLITCH_US    = 1,
  parameter int unsigned SAMPLE_US    = 30,
  parameter int unsigned HOLD_US      = 30,
  parameter int unsigned SLOT_MAX_US  = 120,
  parameter int unsigned RESET_US     = 480,
  parameter int unsigned PRES_DLY_US  = 30,
  parameter int unsigned PRES_WID_US  = 120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_in,
  output logic pull_low,
  output logic rx_valid,
  output logic rx_bit,
  output logic reset_seen,
  input  logic tx_valid,
  input  logic tx_bit,
  output logic tx_ready
);
  localparam int unsigned GL_C   = GLITCH_US   * CLKS_PER_US;
  localparam int unsigned SAMP_C = SAMPLE_US   * CLKS_PER_US;
  localparam int unsigned HOLD_C = HOLD_US     * CLKS_PER_US;
  localparam int unsigned SMAX_C = SLOT_MAX_US * CLKS_PER_US;
  localparam int unsigned RST_C  = RESET_US    * CLKS_PER_US;
  localparam int unsigned PDLY_C = PRES_DLY_US * CLKS_PER_US;
  localparam int unsigned PWID_C = PRES_WID_US * CLKS_PER_US;
  localparam int unsigned TMAX   = max_u(max_u(SMAX_C, PWID_C),
                                         max_u(max_u(PDLY_C, HOLD_C), SAMP_C));
  localparam int unsigned TW     = $clog2(TMAX + 1);

  logic          bus_s, bus_fall, long_low;
  logic [TW-1:0] t;
  logic          t_clr;
  ow_state_e     state_q, state_d;
  logic          bit_q;
  logic          rx_v_d, rx_b_d, pull_d;
  logic          confirm;

  owire_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_raw (bus_in),
    .line_s   (bus_s),
    .line_fall(bus_fall)
  );

  owire_low_meter #(.LIMIT(RST_C)) u_lowm (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_s  (bus_s),
    .long_low(long_low)
  );

  owire_slot_timer #(.TMAX(TMAX)) u_tmr (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (t_clr),
    .t    (t)
  );

  // slot confirmation: line still low once the deglitch time has run
  assign confirm  = (state_q == ST_CONFIRM) && !bus_s && (t == TW'(GL_C - 1)) && !long_low;
  assign tx_ready = confirm;

  always_comb begin
    state_d = state_q;
    t_clr   = 1'b0;
    rx_v_d  = 1'b0;
    rx_b_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (bus_fall) begin
        state_d = ST_CONFIRM;
        t_clr   = 1'b1;
      end
      ST_CONFIRM: begin
        if (bus_s)        state_d = ST_IDLE;
        else if (confirm) state_d = tx_valid ? ST_READ : ST_WSAMP;
      end
      ST_READ: if (t == TW'(HOLD_C - 1)) state_d = ST_WAIT_HI;
      ST_WSAMP: if (t == TW'(SAMP_C - 1)) begin
        if (bus_s) begin
          rx_v_d  = 1'b1;
          rx_b_d  = 1'b1;
          state_d = ST_WAIT_HI;
        end else begin
          state_d = ST_WZERO;
        end
      end
      ST_WZERO: begin
        if (bus_s) begin
          rx_v_d  = 1'b1;
          state_d = ST_IDLE;
        end else if (t == TW'(SMAX_C - 1)) begin
          state_d = ST_WAIT_HI;
        end
      end
      ST_WAIT_HI: if (bus_s) state_d = ST_IDLE;
      ST_RST_HI: if (bus_s) begin
        state_d = ST_PDELAY;
        t_clr   = 1'b1;
      end
      ST_PDELAY: if (t == TW'(PDLY_C - 1)) begin
        state_d = ST_PLOW;
        t_clr   = 1'b1;
      end
      ST_PLOW: if (t == TW'(PWID_C - 1)) state_d = ST_WAIT_HI;
      default: state_d = ST_IDLE;
    endcase
    // a reset-length low wins over every state
    if (long_low) begin
      state_d = ST_RST_HI;
      rx_v_d  = 1'b0;
    end
  end

  assign pull_d = ((state_d == ST_READ) && !((state_q == ST_CONFIRM) ? tx_bit : bit_q))
                || (state_d == ST_PLOW);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      bit_q      <= 1'b1;
      pull_low   <= 1'b0;
      rx_valid   <= 1'b0;
      rx_bit     <= 1'b0;
      reset_seen <= 1'b0;
    end else begin
      state_q    <= state_d;
      if (confirm && tx_valid) bit_q <= tx_bit;
      pull_low   <= pull_d;
      rx_valid   <= rx_v_d;
      rx_bit     <= rx_b_d;
      reset_seen <= long_low;
    end
  end
endmodule

// File: rtl/owire_bit_responder_chk.sv
module owire_bit_responder_chk #(
  parameter int unsigned PWID_C = 6000
) (
  input logic clk,
  input logic rst_n,
  input logic pull_low,
  input logic rx_valid,
  input logic reset_seen,
  input logic tx_ready,
  input logic bus_s
);
  int unsigned pull_run;

  always_ff @(posedge clk) begin
    if (!rst_n)        pull_run <= 0;
    else if (pull_low) pull_run <= pull_run + 1;
    else               pull_run <= 0;
  end

  // R9: strobes last one cycle
  a_r9_rx_single: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);
  a_r1_reset_single: assert property (@(posedge clk) disable iff (!rst_n)
    reset_seen |=> !reset_seen);
  a_r9_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |=> !tx_ready);
  // R1: no pull-down while a reset is being reported
  a_r1_reset_releases: assert property (@(posedge clk) disable iff (!rst_n)
    reset_seen |-> !pull_low);
  // R3 / R4: a bit is only reported after the line was high
  a_r3_rx_after_high: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> $past(bus_s));
  // R7: slot confirmation only while the line is low, never with a received bit
  a_r7_ready_line_low: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !bus_s);
  a_r7_ready_no_rx: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !rx_valid);
  // R9 / R2: no pull-down run longer than the presence width
  a_r9_pull_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    pull_run <= PWID_C);
endmodule

bind owire_bit_responder owire_bit_responder_chk #(.PWID_C(PWID_C)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .pull_low  (pull_low),
  .rx_valid  (rx_valid),
  .reset_seen(reset_seen),
  .tx_ready  (tx_ready),
  .bus_s     (bus_s)
);

// File: tb/test_owire_bit_responder.sv
module test_owire_bit_responder;
  localparam int C = 4;  // cycles per microsecond in this bench

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_low = 1'b0;
  logic tx_valid = 1'b0;
  logic tx_bit = 1'b1;
  logic pull_low, rx_valid, rx_bit, reset_seen, tx_ready;
  wire  bus_in = ~(m_low | pull_low);

  always #2.5 clk = ~clk;

  owire_bit_responder #(.CLKS_PER_US(C)) i_owire_bit_responder (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_in    (bus_in),
    .pull_low  (pull_low),
    .rx_valid  (rx_valid),
    .rx_bit    (rx_bit),
    .reset_seen(reset_seen),
    .tx_valid  (tx_valid),
    .tx_bit    (tx_bit),
    .tx_ready  (tx_ready)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  int rx_cnt = 0, rst_cnt = 0, hs_cnt = 0, pull_cyc = 0;
  logic rx_last = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rx_valid) begin rx_cnt++; rx_last = rx_bit; end
      if (reset_seen) rst_cnt++;
      if (tx_ready && tx_valid) hs_cnt++;
      if (pull_low) pull_cyc++;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  typedef struct packed {
    logic [15:0] low_cyc;
    logic        tv;
    logic        tb;
    logic [1:0]  exp_rx;
    logic        exp_bit;
    logic        exp_hs;
    logic [15:0] exp_pull;
  } vec_t;

  localparam logic [15:0] RD0 = 16'((30 - 1) * C);

  localparam vec_t VEC [10] = '{
    '{16'(5 * C),   1'b0, 1'b1, 2'd1, 1'b1, 1'b0, 16'd0},  // R3 write 1
    '{16'(70 * C),  1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 16'd0},  // R4 write 0
    '{16'(2 * C),   1'b0, 1'b1, 2'd1, 1'b1, 1'b0, 16'd0},  // R3 short write 1
    '{16'(40 * C),  1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 16'd0},  // R4 write 0
    '{16'(2 * C),   1'b1, 1'b0, 2'd0, 1'b0, 1'b1, RD0},    // R7 read 0
    '{16'(2 * C),   1'b1, 1'b1, 2'd0, 1'b0, 1'b1, 16'd0},  // R7 read 1
    '{16'(2),       1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 16'd0},  // R6 glitch
    '{16'(200 * C), 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 16'd0},  // R5 over-long slot
    '{16'(15 * C),  1'b1, 1'b0, 2'd0, 1'b0, 1'b1, RD0},    // R7 read 0, master holds longer
    '{16'(119 * C), 1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 16'd0}   // R4 near slot limit
  };

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic low_for(input int n);
    @(negedge clk);
    m_low = 1'b1;
    repeat (n) @(negedge clk);
    m_low = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int r0, h0, p0, s0, n;
    // R10: reset state
    repeat (4) @(negedge clk);
    chk(!pull_low && !rx_valid && !reset_seen && !tx_ready, "R10 outputs in reset",
        {pull_low, rx_valid, reset_seen, tx_ready}, 0);
    rst_n = 1'b1;
    idle(20);

    for (int i = 0; i < 10; i++) begin
      r0 = rx_cnt; h0 = hs_cnt; p0 = pull_cyc;
      tx_valid = VEC[i].tv;
      tx_bit   = VEC[i].tb;
      low_for(int'(VEC[i].low_cyc));
      idle(150 * C);
      tx_valid = 1'b0;
      tx_bit   = 1'b1;
      idle(10);
      chk(rx_cnt - r0 == int'(VEC[i].exp_rx), $sformatf("R3/R4/R5 vector %0d rx count", i),
          rx_cnt - r0, int'(VEC[i].exp_rx));
      if (VEC[i].exp_rx != 0)
        chk(rx_last == VEC[i].exp_bit, $sformatf("R3/R4 vector %0d rx bit", i),
            int'(rx_last), int'(VEC[i].exp_bit));
      chk(hs_cnt - h0 == int'(VEC[i].exp_hs), $sformatf("R6/R7 vector %0d handshakes", i),
          hs_cnt - h0, int'(VEC[i].exp_hs));
      chk((pull_cyc - p0 >= int'(VEC[i].exp_pull) - 1) && (pull_cyc - p0 <= int'(VEC[i].exp_pull) + 1),
          $sformatf("R7/R9 vector %0d pull cycles", i), pull_cyc - p0, int'(VEC[i].exp_pull));
    end

    // R1 and R2: reset pulse, presence delay and width
    s0 = rst_cnt;
    low_for(500 * C);
    n = 0;
    while (!pull_low && n < 2000) begin @(negedge clk); n++; end
    chk(rst_cnt - s0 == 1, "R1 reset seen once", rst_cnt - s0, 1);
    chk(n >= 30 * C + 2 && n <= 30 * C + 6, "R2 presence delay", n, 30 * C + 4);
    n = 0;
    while (pull_low && n < 2000) begin @(negedge clk); n++; end
    chk(n >= 120 * C - 1 && n <= 120 * C + 1, "R2 presence width", n, 120 * C);
    idle(20);

    // R8: re-arm after presence and after 1 us of recovery
    r0 = rx_cnt;
    low_for(5 * C);
    idle(40 * C);
    m_low = 1'b1;
    idle(70 * C);
    m_low = 1'b0;
    idle(1 * C);
    m_low = 1'b1;
    idle(5 * C);
    m_low = 1'b0;
    idle(60 * C);
    chk(rx_cnt - r0 == 3, "R8 slots after 1 us recovery", rx_cnt - r0, 3);
    chk(rx_last == 1'b1, "R8 last bit", int'(rx_last), 1);

    // R1 boundary: 470 us low is not a reset (and R5: no bit)
    s0 = rst_cnt; r0 = rx_cnt;
    low_for(470 * C);
    idle(200 * C);
    chk(rst_cnt - s0 == 0, "R1 470 us is not reset", rst_cnt - s0, 0);
    chk(rx_cnt - r0 == 0, "R5 470 us gives no bit", rx_cnt - r0, 0);

    // R1: reset recognised from the middle of a read-0 slot
    s0 = rst_cnt;
    tx_valid = 1'b1;
    tx_bit   = 1'b0;
    low_for(490 * C);
    tx_valid = 1'b0;
    tx_bit   = 1'b1;
    n = 0;
    while (!pull_low && n < 2000) begin @(negedge clk); n++; end
    chk(rst_cnt - s0 == 1, "R1 reset from inside a slot", rst_cnt - s0, 1);
    chk(n >= 30 * C + 2 && n <= 30 * C + 6, "R2 presence delay after slot reset", n, 30 * C + 4);
    idle(200 * C);
    chk(!pull_low, "R9 line released after presence", int'(pull_low), 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule